// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a parameterized data cache that sits between a processor load/store port, which moves one 32-bit word per request, and a backing-memory port that moves whole lines. It cuts each request address into three fields. The least significant bits pick a byte within a line. The next bits pick a set. The remaining upper bits form the tag. The stored tags of every way in the chosen set are compared in parallel, and only ways whose valid bit is set can match.

A hit completes in the same cycle as the request. A read returns the addressed word, and a store merges its enabled bytes into the line and marks that line dirty. A miss always moves complete aligned lines. The line to replace is an invalid way if the set has one, and otherwise the least recently used way. If that line is dirty it is first written back in full. The requested line is then fetched, and the request completes as a hit on the new line. Stores that miss therefore allocate: the line is fetched first and then merged.

Top module: `wb_cache`

## Requirements
- R1: The address is split from bit 0 upward into offset, set index and tag. With the defaults (64-byte lines, 64 sets) the offset is bits 5..0, the set is bits 11..6 and the tag is bits 31..12. Address bits 5..2 select the 32-bit word in the line, and `mem_addr` carries address bits 31..6.
- R2: A request whose tag matches a valid way of its set raises `cpu_ready` in the same cycle, without any backing-memory transaction. A read returns the selected word.
- R3: A miss fetches the whole aligned line with exactly one read transaction (`mem_we`=0) at the request's line address before the request completes.
- R4: On a miss, a set that still has an invalid way fills that way, and nothing is evicted or written back.
- R5: On a miss in a full set, the victim is the way that was hit or filled longest ago. Every hit and every fill makes its way the most recently used.
- R6: A store hit writes only the bytes whose `cpu_be` bit is set (bit i covers `cpu_wdata[8i+7:8i]`) and marks the line dirty, with no memory write.
- R7: A store miss first fetches the line and then merges the enabled bytes into it.
- R8: A dirty victim is written back in full (`mem_we`=1, victim's own line address) before the refill read. A clean victim is dropped without a write.
- R9: After reset every way is invalid and clean, so the first access to any line misses, and `cpu_ready` and `mem_req` are low while there is no request.
- R10: `cpu_ready` stays low for the whole miss sequence, until the requested line is resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request valid, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the request |
| cpu_wdata | input | WORD_BYTES*8 | Store data |
| cpu_be | input | WORD_BYTES | Store byte enables |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | WORD_BYTES*8 | Load data, valid with `cpu_ready` |
| mem_req | output | 1 | Backing-memory transaction requested, held until `mem_ack` |
| mem_we | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_addr | output | ADDR_W-log2(LINE_BYTES) | Line address |
| mem_wdata | output | LINE_BYTES*8 | Line being written back |
| mem_ack | input | 1 | One-cycle completion of the transaction |
| mem_rdata | input | LINE_BYTES*8 | Fetched line, valid with `mem_ack` |

## Verification
On a store hit, the byte merge and dirty marking of the line fall on the same clock edge as the LRU update that makes the line most recent. A later miss in the same set depends on both results: which way is chosen, and whether it must be written back. The bench stores into a line, touches a second line, and then forces two more misses into that set. Its queue-based reference model predicts the ordered list of write-backs and fetches with their addresses and line data. Each backing-memory transaction is compared with that list as it happens, and the merged bytes are read again after the line has gone to memory and come back.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WBACK = 2'd1,
      ST_FILL  = 2'd2
   } wbc_state_e;

   function automatic int way_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/wbc_lookup.sv
module wbc_lookup
   import wbc_pkg::*;
#(
   parameter int WAYS  = 2,
   parameter int TAG_W = 20,
   localparam int WAY_W = way_bits(WAYS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [WAYS-1:0]       valid_row,
   input  logic [WAYS*TAG_W-1:0] tag_row,
   input  logic [TAG_W-1:0]      req_tag,
   output logic                  hit,
   output logic [WAY_W-1:0]      hit_way,
   output logic                  free_any,
   output logic [WAY_W-1:0]      free_way
);
   logic [WAYS-1:0] match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = valid_row[w] && (tag_row[w*TAG_W +: TAG_W] == req_tag);
   end

   always_comb begin
      hit      = 1'b0;
      hit_way  = '0;
      free_any = 1'b0;
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match[w]) begin
            hit     = 1'b1;
            hit_way = WAY_W'(w);
         end
         if (!valid_row[w]) begin
            free_any = 1'b1;
            free_way = WAY_W'(w);
         end
      end
   end

   // R2
   single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));
endmodule

// File: rtl/wbc_lru.sv
module wbc_lru
   import wbc_pkg::*;
#(
   parameter int SETS = 64,
   parameter int WAYS = 2,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = way_bits(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_set,
   input  logic             touch_en,
   input  logic [SET_W-1:0] touch_set,
   input  logic [WAY_W-1:0] touch_way,
   output logic [WAY_W-1:0] lru_way
);
   if (WAYS == 1) begin : g_direct
      logic unused_lru;
      assign unused_lru = ^{clk, rst_n, rd_set, touch_en, touch_set, touch_way};
      assign lru_way    = '0;
   end else begin : g_age
      logic [WAY_W-1:0] age_q [SETS][WAYS];
      logic [WAYS-1:0]  present;
      logic [SET_W-1:0] t_set_q;
      logic [WAY_W-1:0] t_way_q;
      logic             t_en_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
               for (int w = 0; w < WAYS; w++)
                  age_q[s][w] <= WAY_W'(w);
         end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
               if (WAY_W'(w) == touch_way)
                  age_q[touch_set][w] <= '0;
               else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                  age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
            end
         end
      end

      always_comb begin
         lru_way = '0;
         present = '0;
         for (int w = 0; w < WAYS; w++) begin
            if (age_q[rd_set][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
            present[age_q[rd_set][w]] = 1'b1;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            t_en_q  <= 1'b0;
            t_set_q <= '0;
            t_way_q <= '0;
         end else begin
            t_en_q  <= touch_en;
            t_set_q <= touch_set;
            t_way_q <= touch_way;
         end
      end

      // R5
      lru_perm_chk: assert property (@(posedge clk) disable iff (!rst_n) (&present));
      // R5
      touch_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
         t_en_q |-> (age_q[t_set_q][t_way_q] == '0));
   end
endmodule

// File: rtl/wb_cache.sv
module wb_cache
   import wbc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int SETS       = 64,
   parameter int WAYS       = 2,
   parameter int WORD_BYTES = 4,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int SET_W     = $clog2(SETS),
   localparam int TAG_W     = ADDR_W - OFF_W - SET_W,
   localparam int WOFF_W    = $clog2(WORD_BYTES),
   localparam int WSEL_W    = OFF_W - WOFF_W,
   localparam int WORD_W    = WORD_BYTES * 8,
   localparam int LINE_W    = LINE_BYTES * 8,
   localparam int WAY_W     = way_bits(WAYS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_req,
   input  logic                    cpu_we,
   input  logic [ADDR_W-1:0]       cpu_addr,
   input  logic [WORD_W-1:0]       cpu_wdata,
   input  logic [WORD_BYTES-1:0]   cpu_be,
   output logic                    cpu_ready,
   output logic [WORD_W-1:0]       cpu_rdata,
   output logic                    mem_req,
   output logic                    mem_we,
   output logic [ADDR_W-OFF_W-1:0] mem_addr,
   output logic [LINE_W-1:0]       mem_wdata,
   input  logic                    mem_ack,
   input  logic [LINE_W-1:0]       mem_rdata
);
   if ((1 << OFF_W) != LINE_BYTES || (1 << SET_W) != SETS || (1 << WOFF_W) != WORD_BYTES)
      begin : g_pow2_bad
         $error("wb_cache: line size, set count and word size must be powers of two");
      end
   if (TAG_W < 1 || WORD_BYTES > LINE_BYTES || WAYS < 1) begin : g_geom_bad
      $error("wb_cache: geometry leaves no tag bits or no words per line");
   end

   // address fields
   logic [TAG_W-1:0]  req_tag;
   logic [SET_W-1:0]  req_set;
   logic [WSEL_W-1:0] req_word;
   logic              unused_lo;
   assign req_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
   assign req_set   = cpu_addr[OFF_W +: SET_W];
   assign req_word  = cpu_addr[WOFF_W +: WSEL_W];
   assign unused_lo = ^cpu_addr[WOFF_W-1:0];

   // line store
   logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
   logic [LINE_W-1:0] line_q [SETS][WAYS];
   logic [WAYS-1:0]   valid_q [SETS];
   logic [WAYS-1:0]   dirty_q [SETS];

   wbc_state_e        st_q;
   logic [WAY_W-1:0]  vic_q;
   logic [TAG_W-1:0]  vtag_q;

   logic [WAYS*TAG_W-1:0] tag_row;
   logic              hit, free_any;
   logic [WAY_W-1:0]  hit_way, free_way, lru_way, vic_way;
   logic [LINE_W-1:0] merged;
   logic              fill_done, touch_en;

   for (genvar w = 0; w < WAYS; w++) begin : g_row
      assign tag_row[w*TAG_W +: TAG_W] = tag_q[req_set][w];
   end

   wbc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
      .clk(clk), .rst_n(rst_n),
      .valid_row(valid_q[req_set]), .tag_row(tag_row), .req_tag(req_tag),
      .hit(hit), .hit_way(hit_way), .free_any(free_any), .free_way(free_way)
   );

   assign fill_done = (st_q == ST_FILL) && mem_ack;
   assign touch_en  = cpu_ready || fill_done;
   assign vic_way   = free_any ? free_way : lru_way;

   wbc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
      .clk(clk), .rst_n(rst_n), .rd_set(req_set),
      .touch_en(touch_en), .touch_set(req_set),
      .touch_way(cpu_ready ? hit_way : vic_q), .lru_way(lru_way)
   );

   assign cpu_ready = (st_q == ST_IDLE) && cpu_req && hit;
   assign cpu_rdata = line_q[req_set][hit_way][int'(req_word)*WORD_W +: WORD_W];
   assign mem_req   = (st_q != ST_IDLE);
   assign mem_we    = (st_q == ST_WBACK);
   assign mem_addr  = (st_q == ST_WBACK) ? {vtag_q, req_set} : {req_tag, req_set};
   assign mem_wdata = line_q[req_set][vic_q];

   always_comb begin
      merged = line_q[req_set][hit_way];
      for (int b = 0; b < WORD_BYTES; b++)
         if (cpu_be[b])
            merged[(int'(req_word)*WORD_BYTES + b)*8 +: 8] = cpu_wdata[b*8 +: 8];
   end

   // control and per-line state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         vic_q  <= '0;
         vtag_q <= '0;
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            dirty_q[s] <= '0;
         end
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (cpu_ready && cpu_we) dirty_q[req_set][hit_way] <= 1'b1;
               if (cpu_req && !hit) begin
                  vic_q  <= vic_way;
                  vtag_q <= tag_q[req_set][vic_way];
                  st_q   <= (valid_q[req_set][vic_way] && dirty_q[req_set][vic_way])
                            ? ST_WBACK : ST_FILL;
               end
            end
            ST_WBACK: if (mem_ack) st_q <= ST_FILL;
            ST_FILL: if (mem_ack) begin
               valid_q[req_set][vic_q] <= 1'b1;
               dirty_q[req_set][vic_q] <= 1'b0;
               st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (fill_done) begin
         line_q[req_set][vic_q] <= mem_rdata;
         tag_q[req_set][vic_q]  <= req_tag;
      end else if (cpu_ready && cpu_we) begin
         line_q[req_set][hit_way] <= merged;
      end
   end

   // checker state
   logic             chk_wr_q;
   logic [SET_W-1:0] chk_set_q;
   logic [WAY_W-1:0] chk_way_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_wr_q  <= 1'b0;
         chk_set_q <= '0;
         chk_way_q <= '0;
      end else begin
         chk_wr_q  <= cpu_ready && cpu_we;
         chk_set_q <= req_set;
         chk_way_q <= hit_way;
      end
   end

   // R10
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |-> !cpu_ready);
   // R2
   hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !mem_req);
   // R6
   dirty_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_wr_q |-> dirty_q[chk_set_q][chk_way_q]);
   // R8
   wb_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WBACK) |-> (valid_q[req_set][vic_q] && dirty_q[req_set][vic_q]));
   // R4
   free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && cpu_req && !hit && !(&valid_q[req_set])) |=> (st_q == ST_FILL));
endmodule

// File: tb/wb_cache_test.sv
module wb_cache_test;
   localparam int ADDR_W = 32, LINE_BYTES = 64, SETS = 64, WAYS = 2, WORD_BYTES = 4;
   localparam int LINE_W = LINE_BYTES * 8, WORD_W = WORD_BYTES * 8;
   localparam int LA_W = ADDR_W - 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cpu_req = 1'b0, cpu_we = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [WORD_W-1:0] cpu_wdata = '0;
   logic [WORD_BYTES-1:0] cpu_be = '0;
   logic cpu_ready;
   logic [WORD_W-1:0] cpu_rdata;
   logic mem_req, mem_we;
   logic [LA_W-1:0] mem_addr;
   logic [LINE_W-1:0] mem_wdata;
   logic mem_ack = 1'b0;
   logic [LINE_W-1:0] mem_rdata = '0;

   int tests = 0, fails = 0;

   always #4 clk = ~clk;

   wb_cache #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SETS(SETS), .WAYS(WAYS),
              .WORD_BYTES(WORD_BYTES)) uut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata));

   // reference model: resident lines per set, most recent first
   int unsigned       res_q [SETS][$];
   logic [LINE_W-1:0] cdata [int unsigned];
   bit                cdirty [int unsigned];
   logic [LINE_W-1:0] mem [int unsigned];
   bit                exp_we [$];
   int unsigned       exp_la [$];
   logic [LINE_W-1:0] exp_ln [$];
   string             exp_rq [$];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [LINE_W-1:0] get_mem(input int unsigned la);
      logic [LINE_W-1:0] l;
      if (mem.exists(la)) return mem[la];
      for (int i = 0; i < LINE_BYTES / WORD_BYTES; i++)
         l[i*WORD_W +: WORD_W] = (la * 32'd16 + 32'(i)) ^ 32'hA5C30000;
      return l;
   endfunction

   // backing memory: acknowledges two cycles after a request appears
   int mcnt = 0;
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
         mcnt = 0;
      end else if (mem_req) begin
         mcnt++;
         if (mcnt == 2) begin
            if (exp_we.size() == 0) begin
               chk(1'b0, "R2", "unexpected memory transaction", LINE_W'(mem_addr), '0);
            end else begin
               string rq;
               rq = exp_rq.pop_front();
               chk(mem_we == exp_we[0], rq, "transaction kind", LINE_W'(mem_we), LINE_W'(exp_we[0]));
               chk(32'(mem_addr) == exp_la[0], rq, "line address", LINE_W'(mem_addr), LINE_W'(exp_la[0]));
               if (exp_we[0])
                  chk(mem_wdata == exp_ln[0], "R8", "write-back data", mem_wdata, exp_ln[0]);
               void'(exp_we.pop_front());
               void'(exp_la.pop_front());
               void'(exp_ln.pop_front());
            end
            if (mem_we) mem[32'(mem_addr)] = mem_wdata;
            else mem_rdata = get_mem(32'(mem_addr));
            mem_ack = 1'b1;
         end
      end else begin
         mcnt = 0;
      end
   end

   function automatic int unsigned mk(input int unsigned tag, input int unsigned set,
                                      input int unsigned off);
      return (tag << 12) | (set << 6) | off;
   endfunction

   // one access; called at a falling edge
   task automatic access(input bit we, input int unsigned addr, input logic [WORD_W-1:0] wd,
                         input logic [WORD_BYTES-1:0] be, input string req);
      int unsigned la, st, wsel;
      int idx, cyc;
      bit hit;
      logic [WORD_W-1:0] exp_rd;
      la   = addr >> 6;
      st   = la % SETS;
      wsel = (addr >> 2) & 15;
      idx  = -1;
      foreach (res_q[st][i]) if (res_q[st][i] == la) idx = i;
      hit = (idx >= 0);
      if (hit) begin
         res_q[st].delete(idx);
      end else begin
         if (res_q[st].size() == WAYS) begin
            int unsigned v;
            v = res_q[st].pop_back();
            if (cdirty[v]) begin
               exp_we.push_back(1'b1); exp_la.push_back(v); exp_ln.push_back(cdata[v]);
               exp_rq.push_back("R8");
            end
            cdata.delete(v); cdirty.delete(v);
         end
         exp_we.push_back(1'b0); exp_la.push_back(la); exp_ln.push_back('0);
         exp_rq.push_back("R3");
         cdata[la]  = get_mem(la);
         cdirty[la] = 1'b0;
      end
      res_q[st].push_front(la);
      exp_rd = cdata[la][wsel*WORD_W +: WORD_W];
      if (we) begin
         for (int b = 0; b < WORD_BYTES; b++)
            if (be[b]) cdata[la][(wsel*WORD_BYTES + b)*8 +: 8] = wd[b*8 +: 8];
         cdirty[la] = 1'b1;
      end
      cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; cpu_be = be;
      cyc = 0;
      forever begin
         #2;
         if (cpu_ready) break;
         @(negedge clk);
         cyc++;
         if (cyc > 60) break;
      end
      if (hit) chk(cyc == 0, req, "hit completes in request cycle", LINE_W'(cyc), 0);
      else chk(cyc > 0 && cyc <= 60, "R10", "miss holds ready low", LINE_W'(cyc), 1);
      if (!we) chk(cpu_rdata == exp_rd, req, "load data", LINE_W'(cpu_rdata), LINE_W'(exp_rd));
      chk(exp_we.size() == 0, req, "pending memory transactions", LINE_W'(exp_we.size()), 0);
      @(negedge clk);
      cpu_req = 1'b0;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      chk(1'b0, "R10", "watchdog expired", '0, '0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(cpu_ready == 1'b0, "R9", "ready after reset", LINE_W'(cpu_ready), 0);
      chk(mem_req == 1'b0, "R9", "mem_req after reset", LINE_W'(mem_req), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R9", "idle outputs", LINE_W'({cpu_ready, mem_req}), 0);
      access(0, mk(1, 5, 8), '0, '0, "R9");                // cold miss
      access(0, mk(1, 5, 12), '0, '0, "R1");               // same line, word 3
      access(0, mk(1, 5, 60), '0, '0, "R2");               // last word of line
      access(1, mk(1, 5, 12), 32'h11223344, 4'b0101, "R6"); // store hit, partial bytes
      access(0, mk(1, 5, 12), '0, '0, "R6");
      access(0, mk(2, 5, 0), '0, '0, "R4");                // free way, no write-back
      access(0, mk(1, 5, 0), '0, '0, "R5");                // line 1 most recent
      access(0, mk(3, 5, 0), '0, '0, "R5");                // evicts clean line 2
      access(0, mk(4, 5, 4), '0, '0, "R8");                // evicts dirty line 1
      access(0, mk(1, 5, 12), '0, '0, "R8");               // merged bytes came back
      access(1, mk(5, 7, 4), 32'hCAFEF00D, 4'b1111, "R7"); // store miss allocates
      access(0, mk(5, 7, 4), '0, '0, "R7");
      access(1, mk(6, 9, 20), 32'h000000AB, 4'b0001, "R7");
      access(0, mk(6, 9, 20), '0, '0, "R7");
      access(0, mk(1, 6, 0), '0, '0, "R1");                // neighbouring set
      access(0, mk(1, 5, 0), '0, '0, "R1");
      for (int n = 0; n < 400; n++) begin
         int unsigned a;
         a = mk($urandom % 6, $urandom % 4, ($urandom % 16) * 4);
         access(($urandom % 3) == 0, a, $urandom, 4'($urandom), "R5");
      end
      finish_run();
   end
endmodule